// File: doc/BRIEF.md
# Segment Base-Bound Address Translator

This block turns a virtual address into a physical one through a small table of segment descriptors held in flip-flops. The upper bits of each incoming virtual address pick one of the table entries, and the remaining low bits are the offset into that segment. Each entry holds three things: a physical base, a limit on the offset, and a valid flag. A request is legal when the entry is valid and the offset does not exceed the limit. For a legal request the block returns base plus offset. Otherwise it returns an access error and a zero address.

Requests arrive with a one-cycle valid strobe. The answer appears on a registered response strobe one cycle later. The table is never read from memory, so a translation has a fixed latency.

Entries are loaded through a write port that only takes effect while the kernel-mode input is high. A write attempted in user mode changes nothing and raises a one-cycle flag instead. After reset every entry is invalid.

Top module: `seg_xlat_top`

## Requirements
- R1: The segment index is the top SEG_W bits of the virtual address. The offset is the remaining low VA_W-SEG_W bits. With the defaults, the index is bits 31:29 and the offset is bits 28:0.
- R2: Response timing:
  - When req_valid_i is high on a clock edge, rsp_valid_o is high for exactly the following cycle.
  - When req_valid_i is low on that edge, rsp_valid_o, rsp_err_o and rsp_paddr_o are all 0 in the following cycle.
- R3: A request that selects an entry whose valid flag is clear returns rsp_err_o=1 with rsp_paddr_o=0.
- R4: A request whose offset is strictly greater than the entry's limit returns rsp_err_o=1 with rsp_paddr_o=0.
- R5: A request whose offset equals the entry's limit is legal.
- R6: A legal request returns rsp_err_o=0 and rsp_paddr_o = base + zero-extended offset, modulo 2^PA_W.
- R7: Reset clears every valid flag. Every request to an entry not yet loaded since reset therefore returns an error.
- R8: Kernel writes:
  - A write with kernel_i=1 replaces the selected entry's base, limit and valid flag at the clock edge.
  - A request sampled on that same edge is translated with the entry's previous contents.
- R9: A write with kernel_i=0 leaves the table unchanged. illegal_wr_o is 1 for exactly the cycle after such a write and 0 otherwise.
- R10: A kernel write with wr_valid_i=0 invalidates the entry, so later requests to it return an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| kernel_i | input | 1 | Privileged mode; enables table writes |
| wr_en_i | input | 1 | Table write strobe |
| wr_idx_i | input | SEG_W | Entry to write |
| wr_base_i | input | PA_W | New physical base |
| wr_limit_i | input | VA_W-SEG_W | New highest legal offset |
| wr_valid_i | input | 1 | New valid flag |
| req_valid_i | input | 1 | Translation request strobe |
| req_vaddr_i | input | VA_W | Virtual address to translate |
| rsp_valid_o | output | 1 | Response strobe, one cycle after a request |
| rsp_err_o | output | 1 | Access error (invalid entry or offset past limit) |
| rsp_paddr_o | output | PA_W | Physical address; zero on error or when idle |
| illegal_wr_o | output | 1 | Pulse after a write attempted in user mode |

## Verification
The checker relies on two assumptions:
- Every input is a known 0 or 1 on each clock edge while reset is released.
- Each request strobe is judged on its own, so back-to-back requests are legal and each produces its own response cycle.

Its never-loaded-entry property counts only kernel writes since reset. It therefore depends on kernel_i and wr_en_i being driven cleanly; the stimulus changes them only at the falling clock edge.

The random stimulus draws offsets close to each limit (one below, equal, one above) as well as anywhere in the offset range. It mixes user-mode writes into kernel writes, so the bound, validity and privilege paths are all reached.

// File: rtl/seg_xlat_pkg.sv
package seg_xlat_pkg;

  // Outcome of one lookup
  typedef enum logic [1:0] {
    CHK_OK      = 2'd0,
    CHK_INVALID = 2'd1,
    CHK_BOUND   = 2'd2
  } chk_e;

  localparam int unsigned DEF_VA_W  = 32;
  localparam int unsigned DEF_PA_W  = 32;
  localparam int unsigned DEF_SEG_W = 3;

endpackage

// File: rtl/seg_table.sv
module seg_table #(
  parameter int unsigned SEG_W = 3,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 29
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             kernel_i,
  input  logic             wr_en_i,
  input  logic [SEG_W-1:0] wr_idx_i,
  input  logic [PA_W-1:0]  wr_base_i,
  input  logic [OFF_W-1:0] wr_limit_i,
  input  logic             wr_valid_i,
  input  logic [SEG_W-1:0] rd_idx_i,
  output logic [PA_W-1:0]  rd_base_o,
  output logic [OFF_W-1:0] rd_limit_o,
  output logic             rd_valid_o,
  output logic             illegal_wr_o
);
  localparam int unsigned NUM_SEG = 1 << SEG_W;

  logic               wr_ok;
  logic               wr_bad;
  logic [PA_W-1:0]    base_all  [NUM_SEG];
  logic [OFF_W-1:0]   limit_all [NUM_SEG];
  logic [NUM_SEG-1:0] valid_all;
  logic               illegal_q;

  assign wr_ok  = wr_en_i &  kernel_i;
  assign wr_bad = wr_en_i & ~kernel_i;

  for (genvar g = 0; g < NUM_SEG; g++) begin : g_ent
    logic             sel;
    logic [PA_W-1:0]  base_q;
    logic [OFF_W-1:0] limit_q;
    logic             valid_q;

    assign sel = wr_ok && (wr_idx_i == SEG_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        base_q  <= '0;
        limit_q <= '0;
        valid_q <= 1'b0;
      end else if (sel) begin
        base_q  <= wr_base_i;
        limit_q <= wr_limit_i;
        valid_q <= wr_valid_i;
      end
    end

    assign base_all[g]  = base_q;
    assign limit_all[g] = limit_q;
    assign valid_all[g] = valid_q;
  end

  // Reads see the contents before any write on the same edge
  assign rd_base_o  = base_all[rd_idx_i];
  assign rd_limit_o = limit_all[rd_idx_i];
  assign rd_valid_o = valid_all[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) illegal_q <= 1'b0;
    else         illegal_q <= wr_bad;
  end

  assign illegal_wr_o = illegal_q;
endmodule

// File: rtl/seg_check.sv
module seg_check
  import seg_xlat_pkg::*;
#(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned SEG_W = 3,
  parameter int unsigned OFF_W = VA_W - SEG_W
) (
  input  logic [VA_W-1:0]  vaddr_i,
  input  logic [PA_W-1:0]  base_i,
  input  logic [OFF_W-1:0] limit_i,
  input  logic             valid_i,
  output logic [SEG_W-1:0] seg_idx_o,
  output logic [PA_W-1:0]  paddr_o,
  output chk_e             result_o
);
  logic [OFF_W-1:0] offset;
  logic [PA_W-1:0]  off_ext;

  assign seg_idx_o = vaddr_i[VA_W-1 -: SEG_W];
  assign offset    = vaddr_i[OFF_W-1:0];

  if (PA_W > OFF_W) begin : g_zext
    assign off_ext = {{(PA_W - OFF_W){1'b0}}, offset};
  end else if (PA_W == OFF_W) begin : g_same
    assign off_ext = offset;
  end else begin : g_trunc
    assign off_ext = offset[PA_W-1:0];
  end

  // Bound compare and base add run side by side
  assign paddr_o = base_i + off_ext;

  always_comb begin
    if (!valid_i)             result_o = CHK_INVALID;
    else if (offset > limit_i) result_o = CHK_BOUND;
    else                      result_o = CHK_OK;
  end
endmodule

// File: rtl/seg_rsp_reg.sv
module seg_rsp_reg
  import seg_xlat_pkg::*;
#(
  parameter int unsigned PA_W = 32
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            req_valid_i,
  input  chk_e            result_i,
  input  logic [PA_W-1:0] paddr_i,
  output logic            rsp_valid_o,
  output logic            rsp_err_o,
  output logic [PA_W-1:0] rsp_paddr_o
);
  logic ok;
  assign ok = (result_i == CHK_OK);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_err_o   <= 1'b0;
      rsp_paddr_o <= '0;
    end else begin
      rsp_valid_o <= req_valid_i;
      rsp_err_o   <= req_valid_i & ~ok;
      rsp_paddr_o <= (req_valid_i && ok) ? paddr_i : '0;
    end
  end
endmodule

// File: rtl/seg_xlat_top.sv
module seg_xlat_top
  import seg_xlat_pkg::*;
#(
  parameter int unsigned VA_W  = DEF_VA_W,
  parameter int unsigned PA_W  = DEF_PA_W,
  parameter int unsigned SEG_W = DEF_SEG_W
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    kernel_i,
  input  logic                    wr_en_i,
  input  logic [SEG_W-1:0]        wr_idx_i,
  input  logic [PA_W-1:0]         wr_base_i,
  input  logic [VA_W-SEG_W-1:0]   wr_limit_i,
  input  logic                    wr_valid_i,
  input  logic                    req_valid_i,
  input  logic [VA_W-1:0]         req_vaddr_i,
  output logic                    rsp_valid_o,
  output logic                    rsp_err_o,
  output logic [PA_W-1:0]         rsp_paddr_o,
  output logic                    illegal_wr_o
);
  localparam int unsigned OFF_W = VA_W - SEG_W;

  logic [SEG_W-1:0] seg_idx;
  logic [PA_W-1:0]  ent_base;
  logic [OFF_W-1:0] ent_limit;
  logic             ent_valid;
  logic [PA_W-1:0]  sum_paddr;
  chk_e             result;

  seg_table #(.SEG_W(SEG_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_table (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .kernel_i    (kernel_i),
    .wr_en_i     (wr_en_i),
    .wr_idx_i    (wr_idx_i),
    .wr_base_i   (wr_base_i),
    .wr_limit_i  (wr_limit_i),
    .wr_valid_i  (wr_valid_i),
    .rd_idx_i    (seg_idx),
    .rd_base_o   (ent_base),
    .rd_limit_o  (ent_limit),
    .rd_valid_o  (ent_valid),
    .illegal_wr_o(illegal_wr_o)
  );

  seg_check #(.VA_W(VA_W), .PA_W(PA_W), .SEG_W(SEG_W), .OFF_W(OFF_W)) u_check (
    .vaddr_i  (req_vaddr_i),
    .base_i   (ent_base),
    .limit_i  (ent_limit),
    .valid_i  (ent_valid),
    .seg_idx_o(seg_idx),
    .paddr_o  (sum_paddr),
    .result_o (result)
  );

  seg_rsp_reg #(.PA_W(PA_W)) u_rsp (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .req_valid_i(req_valid_i),
    .result_i   (result),
    .paddr_i    (sum_paddr),
    .rsp_valid_o(rsp_valid_o),
    .rsp_err_o  (rsp_err_o),
    .rsp_paddr_o(rsp_paddr_o)
  );
endmodule

// File: rtl/seg_xlat_chk.sv
module seg_xlat_chk #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned SEG_W = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             kernel_i,
  input logic             wr_en_i,
  input logic [SEG_W-1:0] wr_idx_i,
  input logic             req_valid_i,
  input logic [VA_W-1:0]  req_vaddr_i,
  input logic             rsp_valid_o,
  input logic             rsp_err_o,
  input logic [PA_W-1:0]  rsp_paddr_o,
  input logic             illegal_wr_o
);
  localparam int unsigned NUM_SEG = 1 << SEG_W;

  // Entries touched by any kernel write since reset
  logic [NUM_SEG-1:0] touched_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) touched_q <= '0;
    else if (wr_en_i && kernel_i) touched_q[wr_idx_i] <= 1'b1;
  end

  p_rsp_after_req_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> rsp_valid_o);

  p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> (!rsp_valid_o && !rsp_err_o && rsp_paddr_o == '0));

  p_err_zero_addr_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_err_o |-> (rsp_valid_o && rsp_paddr_o == '0));

  p_unloaded_err_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !touched_q[req_vaddr_i[VA_W-1 -: SEG_W]]) |=> rsp_err_o);

  p_user_wr_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !kernel_i) |=> illegal_wr_o);

  p_no_spurious_flag_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(wr_en_i && !kernel_i) |=> !illegal_wr_o);
endmodule

bind seg_xlat_top seg_xlat_chk #(.VA_W(VA_W), .PA_W(PA_W), .SEG_W(SEG_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .kernel_i    (kernel_i),
  .wr_en_i     (wr_en_i),
  .wr_idx_i    (wr_idx_i),
  .req_valid_i (req_valid_i),
  .req_vaddr_i (req_vaddr_i),
  .rsp_valid_o (rsp_valid_o),
  .rsp_err_o   (rsp_err_o),
  .rsp_paddr_o (rsp_paddr_o),
  .illegal_wr_o(illegal_wr_o)
);

// File: tb/tb_seg_xlat_top.sv
module tb_seg_xlat_top;
  localparam int unsigned VA_W   = 32;
  localparam int unsigned PA_W   = 32;
  localparam int unsigned SEG_W  = 3;
  localparam int unsigned OFF_W  = VA_W - SEG_W;
  localparam int unsigned NSEG   = 1 << SEG_W;
  localparam time         CLK_PERIOD = 10ns;

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             kernel_i = 1'b0;
  logic             wr_en_i = 1'b0;
  logic [SEG_W-1:0] wr_idx_i = '0;
  logic [PA_W-1:0]  wr_base_i = '0;
  logic [OFF_W-1:0] wr_limit_i = '0;
  logic             wr_valid_i = 1'b0;
  logic             req_valid_i = 1'b0;
  logic [VA_W-1:0]  req_vaddr_i = '0;
  logic             rsp_valid_o;
  logic             rsp_err_o;
  logic [PA_W-1:0]  rsp_paddr_o;
  logic             illegal_wr_o;

  int unsigned n_vec = 0;
  int unsigned n_bad = 0;

  // Reference table
  logic [PA_W-1:0]  m_base  [NSEG];
  logic [OFF_W-1:0] m_limit [NSEG];
  logic             m_valid [NSEG];

  always #(CLK_PERIOD / 2) clk_i = ~clk_i;

  seg_xlat_top #(.VA_W(VA_W), .PA_W(PA_W), .SEG_W(SEG_W)) dut (.*);

  function automatic string tag_for(input logic req, input logic [VA_W-1:0] va);
    logic [SEG_W-1:0] s;
    logic [OFF_W-1:0] o;
    s = va[VA_W-1 -: SEG_W];
    o = va[OFF_W-1:0];
    if (!req)                return "R2";
    else if (!m_valid[s])    return "R3/R7";
    else if (o > m_limit[s]) return "R4";
    else if (o == m_limit[s]) return "R5";
    else                     return "R6";
  endfunction

  function automatic void predict(input logic req, input logic [VA_W-1:0] va,
                                  output logic ev, output logic ee, output logic [PA_W-1:0] ep);
    logic [SEG_W-1:0] s;
    logic [OFF_W-1:0] o;
    s  = va[VA_W-1 -: SEG_W];   // R1 split
    o  = va[OFF_W-1:0];
    ev = req;
    ee = 1'b0;
    ep = '0;
    if (req) begin
      if (!m_valid[s] || o > m_limit[s]) ee = 1'b1;
      else ep = m_base[s] + PA_W'(o);
    end
  endfunction

  // One cycle: drive at falling edge, check after the next rising edge
  task automatic cyc(input logic k, input logic we, input logic [SEG_W-1:0] wi,
                     input logic [PA_W-1:0] wb, input logic [OFF_W-1:0] wl, input logic wv,
                     input logic rq, input logic [VA_W-1:0] va);
    logic ev, ee, ei;
    logic [PA_W-1:0] ep;
    string tg;
    kernel_i = k; wr_en_i = we; wr_idx_i = wi; wr_base_i = wb;
    wr_limit_i = wl; wr_valid_i = wv; req_valid_i = rq; req_vaddr_i = va;
    predict(rq, va, ev, ee, ep);   // old contents (R8)
    tg = tag_for(rq, va);
    ei = we & ~k;
    if (we && k) begin
      m_base[wi] = wb; m_limit[wi] = wl; m_valid[wi] = wv;
    end
    @(negedge clk_i);
    n_vec++;
    if (rsp_valid_o !== ev || rsp_err_o !== ee || rsp_paddr_o !== ep) begin
      n_bad++;
      $display("FAIL %s: got v=%0b e=%0b pa=%h, want v=%0b e=%0b pa=%h",
               tg, rsp_valid_o, rsp_err_o, rsp_paddr_o, ev, ee, ep);
    end
    n_vec++;
    if (illegal_wr_o !== ei) begin
      n_bad++;
      $display("FAIL R9: illegal_wr_o got %0b want %0b", illegal_wr_o, ei);
    end
  endtask

  task automatic kwrite(input logic [SEG_W-1:0] i, input logic [PA_W-1:0] b,
                        input logic [OFF_W-1:0] l, input logic v);
    cyc(1'b1, 1'b1, i, b, l, v, 1'b0, '0);
  endtask

  task automatic req(input logic [SEG_W-1:0] s, input logic [OFF_W-1:0] o);
    cyc(1'b0, 1'b0, '0, '0, '0, 1'b0, 1'b1, {s, o});
  endtask

  initial begin
    repeat (2000000) @(posedge clk_i);
    n_bad++;
    $display("FAIL R2: watchdog expired, got no completion, want completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    logic [OFF_W-1:0] lim, off;
    logic [SEG_W-1:0] s;
    int unsigned pick;
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < NSEG; i++) begin
      m_base[i] = '0; m_limit[i] = '0; m_valid[i] = 1'b0;
    end
    repeat (3) @(negedge clk_i);
    // Reset state: outputs quiet (R2)
    n_vec++;
    if (rsp_valid_o !== 1'b0 || rsp_err_o !== 1'b0 || rsp_paddr_o !== '0 || illegal_wr_o !== 1'b0) begin
      n_bad++;
      $display("FAIL R2: reset outputs got v=%0b e=%0b pa=%h i=%0b, want all 0",
               rsp_valid_o, rsp_err_o, rsp_paddr_o, illegal_wr_o);
    end
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R7: every entry invalid after reset
    for (int i = 0; i < NSEG; i++) req(SEG_W'(i), OFF_W'(0));

    // R1/R6: load segment 5, translate inside it
    kwrite(3'd5, 32'h1000_0000, OFF_W'(32'h100), 1'b1);
    req(3'd5, OFF_W'(32'h20));
    req(3'd4, OFF_W'(32'h20));            // R1: neighbour still invalid
    req(3'd5, OFF_W'(32'h100));           // R5: exactly at limit
    req(3'd5, OFF_W'(32'h101));           // R4: one past limit
    // R6: base wraps modulo 2^PA_W
    kwrite(3'd7, 32'hFFFF_FFF0, OFF_W'(32'h40), 1'b1);
    req(3'd7, OFF_W'(32'h20));
    // R9: user write ignored, table read back unchanged
    cyc(1'b0, 1'b1, 3'd5, 32'h2222_0000, '1, 1'b1, 1'b0, '0);
    req(3'd5, OFF_W'(32'h200));
    req(3'd5, OFF_W'(32'h10));
    // R8: write and request on the same edge uses old entry
    cyc(1'b1, 1'b1, 3'd5, 32'h3000_0000, OFF_W'(32'h800), 1'b1, 1'b1, {3'd5, OFF_W'(32'h400)});
    req(3'd5, OFF_W'(32'h400));
    // R10: invalidate
    kwrite(3'd5, 32'h3000_0000, OFF_W'(32'h800), 1'b0);
    req(3'd5, OFF_W'(32'h1));
    // Back-to-back requests (R2)
    req(3'd7, '0);
    req(3'd7, OFF_W'(32'h40));
    // Max limit: any offset legal
    kwrite(3'd0, 32'h0000_1000, '1, 1'b1);
    req(3'd0, '1);

    // Constrained random
    for (int n = 0; n < 4000; n++) begin
      pick = $urandom_range(0, 9);
      s = SEG_W'($urandom);
      if (pick < 2) begin
        lim = (pick == 0) ? OFF_W'($urandom_range(0, 4095)) : OFF_W'($urandom);
        cyc(($urandom_range(0, 3) != 0), 1'b1, s, PA_W'($urandom), lim,
            ($urandom_range(0, 4) != 0), 1'($urandom), {SEG_W'($urandom), OFF_W'($urandom)});
      end else if (pick < 8) begin
        lim = m_limit[s];
        case ($urandom_range(0, 3))
          0: off = lim;
          1: off = lim + OFF_W'(1);
          2: off = lim - OFF_W'(1);
          default: off = OFF_W'($urandom);
        endcase
        req(s, off);
      end else begin
        cyc(1'($urandom), 1'b0, '0, '0, '0, 1'b0, 1'b0, '0);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule